// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the data address for load and store operations in a 32-bit RISC pipeline. Each cycle it may accept one request carrying the base register value, an index register value, a 16-bit immediate displacement, an addressing-mode code, an operand-size code, the base register number and an update flag. One cycle later it presents the effective address, the echoed operand size and a valid strobe.

Three addressing modes are supported. The first adds the sign-extended immediate to the base. The second adds a second register to the base. The third uses the base value alone. The two indexed modes may also request an update. In that case the computed address is used for the access and is also offered back to the register file as a base write-back, together with the base register number.

Some requests do not form a legal combination: an update in plain register mode, the reserved mode code, or the reserved size code. These requests raise an illegal-form strobe in place of the access and the write-back.

Top module: `ls_addr_gen`

## Requirements
- R1: With mode code 0 (base plus immediate), the effective address equals the base plus the 16-bit immediate sign-extended to 32 bits, with the sum wrapping modulo 2^32.
- R2: With mode code 1 (base plus index register), the effective address equals the base plus the index value, with the sum wrapping modulo 2^32.
- R3: With mode code 2 (register only), the effective address equals the base value, and the index and immediate inputs have no effect on it.
- R4: A legal request in mode 0 or 1 with the update flag set raises wbValid for exactly one cycle. In that cycle wbIdx equals the request's base register number and wbAddr equals eaAddr.
- R5: A legal request with the update flag clear leaves wbValid low.
- R6: Results appear in the cycle after the request is sampled. eaValid is high for one cycle, and eaSize echoes the size code (0 byte, 1 halfword, 2 word).
- R7: In a cycle with no request sampled, eaValid, wbValid and illegalForm are all low in the next cycle, and eaAddr keeps its previous value.
- R8: A request with the update flag set in mode 2, with mode code 3, or with size code 3 raises illegalForm for one cycle. eaValid and wbValid stay low and eaAddr keeps its previous value.
- R9: While reset (rstN low) is applied, eaValid, wbValid and illegalForm are low, and eaAddr and wbAddr are zero.
- R10: Requests on consecutive cycles each produce their own result on consecutive cycles, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | A request is present this cycle |
| mode | input | 2 | Addressing mode: 0 base+immediate, 1 base+index, 2 register only, 3 reserved |
| update | input | 1 | Write the computed address back to the base register |
| size | input | 2 | Operand size: 0 byte, 1 halfword, 2 word, 3 reserved |
| baseVal | input | 32 | Base register value |
| indexVal | input | 32 | Index register value |
| imm | input | 16 | Immediate displacement, signed |
| baseIdx | input | 5 | Base register number |
| eaValid | output | 1 | Effective address valid |
| eaAddr | output | 32 | Effective address |
| eaSize | output | 2 | Operand size of the access |
| wbValid | output | 1 | Base write-back request |
| wbIdx | output | 5 | Register number to write back |
| wbAddr | output | 32 | Value to write back |
| illegalForm | output | 1 | The request was an illegal combination |

## Verification
The checker follows several properties on every cycle. It checks the arithmetic of each mode against the inputs of the previous cycle. It checks that a write-back always coincides with a valid access to the same address, that an illegal form excludes both the access and the write-back, and that an idle cycle produces no strobes. Some behaviours need the bench's scenarios to show: address holding across idle and illegal cycles, wrap-around at the top of the address space, unrelated inputs having no effect in register-only mode, and streams of back-to-back mixed requests. The bench covers these against its reference model, which it compares with the outputs on every clock.

// File: rtl/ls_addr_gen_pkg.sv
package ls_addr_gen_pkg;

  typedef enum logic [1:0] {
    AM_IMM = 2'd0,
    AM_IDX = 2'd1,
    AM_REG = 2'd2,
    AM_RSV = 2'd3
  } addrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new effective address
    logic useIndex;  // offset from the index register
    logic useImm;    // offset from the sign-extended immediate
    logic wbLoad;    // capture the write-back address and index
  } dpCtl_t;

endpackage

// File: rtl/ls_addr_gen_ctl.sv
module ls_addr_gen_ctl
  import ls_addr_gen_pkg::*;
#(
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        mode,
  input  logic              update,
  input  logic [SIZE_W-1:0] size,
  output dpCtl_t            ctl,
  output logic              eaValid,
  output logic              wbValid,
  output logic              illegalForm
);

  localparam logic [SIZE_W-1:0] SIZE_RSV = '1;

  logic modeOk;
  logic sizeOk;
  logic formOk;
  logic legal;
  logic illegal;

  always_comb begin
    modeOk  = (addrMode_e'(mode) != AM_RSV);
    sizeOk  = (size != SIZE_RSV);
    formOk  = !(update && (addrMode_e'(mode) == AM_REG));
    legal   = reqValid && modeOk && sizeOk && formOk;
    illegal = reqValid && !legal;

    ctl.load     = legal;
    ctl.useIndex = (addrMode_e'(mode) == AM_IDX);
    ctl.useImm   = (addrMode_e'(mode) == AM_IMM);
    ctl.wbLoad   = legal && update;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaValid     <= 1'b0;
      wbValid     <= 1'b0;
      illegalForm <= 1'b0;
    end else begin
      eaValid     <= legal;
      wbValid     <= legal && update;
      illegalForm <= illegal;
    end
  end

endmodule

// File: rtl/ls_addr_gen_dp.sv
module ls_addr_gen_dp
  import ls_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [IMM_W-1:0]  imm,
  input  logic [IDX_W-1:0]  baseIdx,
  input  logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] eaAddr,
  output logic [SIZE_W-1:0] eaSize,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [IDX_W-1:0]  wbIdx
);

  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] immExt;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    immExt = {{EXT_W{imm[IMM_W-1]}}, imm};
    if (ctl.useIndex)    offset = indexVal;
    else if (ctl.useImm) offset = immExt;
    else                 offset = '0;
    sum = baseVal + offset;  // wraps at the address width
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaAddr <= '0;
      eaSize <= '0;
      wbAddr <= '0;
      wbIdx  <= '0;
    end else begin
      if (ctl.load) begin
        eaAddr <= sum;
        eaSize <= size;
      end
      if (ctl.wbLoad) begin
        wbAddr <= sum;
        wbIdx  <= baseIdx;
      end
    end
  end

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
  import ls_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        mode,
  input  logic              update,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [IMM_W-1:0]  imm,
  input  logic [IDX_W-1:0]  baseIdx,
  output logic              eaValid,
  output logic [ADDR_W-1:0] eaAddr,
  output logic [SIZE_W-1:0] eaSize,
  output logic              wbValid,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [ADDR_W-1:0] wbAddr,
  output logic              illegalForm
);

  dpCtl_t ctl;

  ls_addr_gen_ctl #(.SIZE_W(SIZE_W)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .mode        (mode),
    .update      (update),
    .size        (size),
    .ctl         (ctl),
    .eaValid     (eaValid),
    .wbValid     (wbValid),
    .illegalForm (illegalForm)
  );

  ls_addr_gen_dp #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .IDX_W  (IDX_W),
    .SIZE_W (SIZE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .baseVal  (baseVal),
    .indexVal (indexVal),
    .imm      (imm),
    .baseIdx  (baseIdx),
    .size     (size),
    .eaAddr   (eaAddr),
    .eaSize   (eaSize),
    .wbAddr   (wbAddr),
    .wbIdx    (wbIdx)
  );

endmodule

// File: rtl/ls_addr_gen_chk.sv
module ls_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5,
  parameter int SIZE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        mode,
  input logic              update,
  input logic [SIZE_W-1:0] size,
  input logic [ADDR_W-1:0] baseVal,
  input logic [ADDR_W-1:0] indexVal,
  input logic [IMM_W-1:0]  imm,
  input logic [IDX_W-1:0]  baseIdx,
  input logic              eaValid,
  input logic [ADDR_W-1:0] eaAddr,
  input logic              wbValid,
  input logic [IDX_W-1:0]  wbIdx,
  input logic [ADDR_W-1:0] wbAddr,
  input logic              illegalForm
);

  localparam int EXT_W = ADDR_W - IMM_W;
  localparam logic [SIZE_W-1:0] SIZE_RSV = '1;

  p_imm_sum_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 2'd0 && size != SIZE_RSV) |=>
      (eaValid && eaAddr == $past(baseVal) + {{EXT_W{$past(imm[IMM_W-1])}}, $past(imm)}));

  p_idx_sum_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 2'd1 && size != SIZE_RSV) |=>
      (eaValid && eaAddr == $past(baseVal) + $past(indexVal)));

  p_reg_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && mode == 2'd2 && !update && size != SIZE_RSV) |=>
      (eaValid && eaAddr == $past(baseVal)));

  p_wb_matches_ea_r4: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (eaValid && wbAddr == eaAddr));

  p_wb_index_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && update && mode != 2'd2 && mode != 2'd3 && size != SIZE_RSV) |=>
      (wbValid && wbIdx == $past(baseIdx)));

  p_no_update_no_wb_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !update) |=> !wbValid);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!eaValid && !wbValid && !illegalForm && $stable(eaAddr)));

  p_illegal_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegalForm |-> (!eaValid && !wbValid));

  p_strobes_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eaValid, illegalForm}));

endmodule

bind ls_addr_gen ls_addr_gen_chk #(
  .ADDR_W (ADDR_W),
  .IMM_W  (IMM_W),
  .IDX_W  (IDX_W),
  .SIZE_W (SIZE_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .mode        (mode),
  .update      (update),
  .size        (size),
  .baseVal     (baseVal),
  .indexVal    (indexVal),
  .imm         (imm),
  .baseIdx     (baseIdx),
  .eaValid     (eaValid),
  .eaAddr      (eaAddr),
  .wbValid     (wbValid),
  .wbIdx       (wbIdx),
  .wbAddr      (wbAddr),
  .illegalForm (illegalForm)
);

// File: tb/ls_addr_gen_test.sv
`timescale 1ns/1ps
module ls_addr_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        update = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [31:0] baseVal = 32'd0;
  logic [31:0] indexVal = 32'd0;
  logic [15:0] imm = 16'd0;
  logic [4:0]  baseIdx = 5'd0;
  logic        eaValid;
  logic [31:0] eaAddr;
  logic [1:0]  eaSize;
  logic        wbValid;
  logic [4:0]  wbIdx;
  logic [31:0] wbAddr;
  logic        illegalForm;

  int checks = 0;
  int fails  = 0;
  bit running = 1'b0;
  string curTag = "R7";

  always #2 clk = ~clk;

  ls_addr_gen uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode), .update(update),
    .size(size), .baseVal(baseVal), .indexVal(indexVal), .imm(imm),
    .baseIdx(baseIdx), .eaValid(eaValid), .eaAddr(eaAddr), .eaSize(eaSize),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbAddr(wbAddr), .illegalForm(illegalForm)
  );

  // behavioural reference model
  logic        expEaValid = 0, expWbValid = 0, expIll = 0;
  logic [31:0] expEa = 0, expWbAddr = 0;
  logic [1:0]  expSize = 0;
  logic [4:0]  expWbIdx = 0;
  string       expTag = "R9";

  always @(posedge clk) begin
    bit ok;
    longint unsigned full;
    logic [31:0] ea;
    if (!rstN) begin
      expEaValid <= 0; expWbValid <= 0; expIll <= 0;
      expEa <= 0; expWbAddr <= 0; expSize <= 0; expWbIdx <= 0;
      expTag <= "R9";
    end else begin
      ok = reqValid && mode != 2'd3 && size != 2'd3 && !(update && mode == 2'd2);
      case (mode)
        2'd0: full = longint'(baseVal) + longint'(unsigned'(32'(signed'(imm))));
        2'd1: full = longint'(baseVal) + longint'(indexVal);
        default: full = longint'(baseVal);
      endcase
      ea = full[31:0];
      expEaValid <= ok;
      expWbValid <= ok && update;
      expIll     <= reqValid && !ok;
      if (ok) begin
        expEa <= ea;
        expSize <= size;
        if (update) begin
          expWbAddr <= ea;
          expWbIdx <= baseIdx;
        end
      end
      expTag <= curTag;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      check(expTag, "eaValid", 32'(eaValid), 32'(expEaValid));
      check(expTag, "wbValid", 32'(wbValid), 32'(expWbValid));
      check(expTag, "illegalForm", 32'(illegalForm), 32'(expIll));
      check(expTag, "eaAddr", eaAddr, expEa);
      if (expEaValid) check(expTag, "eaSize", 32'(eaSize), 32'(expSize));
      if (expWbValid) begin
        check(expTag, "wbAddr", wbAddr, expWbAddr);
        check(expTag, "wbIdx", 32'(wbIdx), 32'(expWbIdx));
      end
    end
  end

  task automatic req(input logic [1:0] m, input logic u, input logic [1:0] s,
                     input logic [31:0] b, input logic [31:0] x,
                     input logic [15:0] i, input logic [4:0] r, input string tag);
    @(negedge clk);
    reqValid = 1'b1; mode = m; update = u; size = s;
    baseVal = b; indexVal = x; imm = i; baseIdx = r; curTag = tag;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reqValid = 1'b0; curTag = "R7";
      baseVal = 32'hDEAD_0000 + 32'(k); indexVal = 32'h1234_5678; imm = 16'h7FFF;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values while rstN is low
    check("R9", "eaValid", 32'(eaValid), 32'd0);
    check("R9", "wbValid", 32'(wbValid), 32'd0);
    check("R9", "illegalForm", 32'(illegalForm), 32'd0);
    check("R9", "eaAddr", eaAddr, 32'd0);
    check("R9", "wbAddr", wbAddr, 32'd0);
    rstN = 1'b1;
    running = 1'b1;
    idle(2);
    req(2'd0, 1'b0, 2'd2, 32'h0000_1000, 32'h0, 16'h0040, 5'd3, "R1");
    req(2'd0, 1'b0, 2'd1, 32'h0000_1000, 32'h0, 16'hFFF0, 5'd3, "R1");
    req(2'd0, 1'b0, 2'd0, 32'hFFFF_FFF0, 32'h0, 16'h0020, 5'd3, "R1");
    idle(1);
    req(2'd1, 1'b0, 2'd2, 32'h0001_0000, 32'h0000_0234, 16'h8000, 5'd4, "R2");
    req(2'd1, 1'b0, 2'd2, 32'h8000_0000, 32'h8000_0004, 16'h0, 5'd4, "R2");
    idle(1);
    req(2'd2, 1'b0, 2'd2, 32'h0000_ABC0, 32'hFFFF_FFFF, 16'h7FFF, 5'd5, "R3");
    req(2'd2, 1'b0, 2'd1, 32'h0000_ABC0, 32'h0000_0001, 16'h8000, 5'd5, "R3");
    idle(1);
    req(2'd0, 1'b1, 2'd2, 32'h2000_0000, 32'h0, 16'hFFFC, 5'd7, "R4");
    idle(1);
    req(2'd1, 1'b1, 2'd0, 32'h3000_0000, 32'h0000_0010, 16'h0, 5'd31, "R4");
    idle(1);
    req(2'd1, 1'b0, 2'd2, 32'h4000_0000, 32'h0000_0008, 16'h0, 5'd9, "R5");
    idle(1);
    req(2'd0, 1'b0, 2'd0, 32'h5000_0000, 32'h0, 16'h0003, 5'd1, "R6");
    req(2'd0, 1'b0, 2'd1, 32'h5000_0000, 32'h0, 16'h0006, 5'd1, "R6");
    idle(3);
    req(2'd2, 1'b1, 2'd2, 32'h6000_0000, 32'h0, 16'h0, 5'd2, "R8");
    req(2'd3, 1'b0, 2'd2, 32'h6100_0000, 32'h0, 16'h0, 5'd2, "R8");
    req(2'd0, 1'b1, 2'd3, 32'h6200_0000, 32'h0, 16'h0, 5'd2, "R8");
    idle(1);
    for (int k = 0; k < 12; k++)
      req(2'(k % 3), 1'(k % 2), 2'(k % 3), 32'h7000_0000 + 32'(k * 64),
          32'(k * 3), 16'(k * 5 - 20), 5'(k), "R10");
    idle(3);
    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule